// File: doc/BRIEF.md
# Two-Stage Memory Attribute Remapper

This block turns the raw attribute bits of a page-table entry into the final memory attributes used by the memory system: memory type, shareability and the inner and outer cacheability. Remapping runs as a chain of two table lookups. The first stage picks a memory type and a shareable flag. The second stage picks the cacheability and is used only when the first stage returns Normal memory. The lookup index is three bits wide: the lowest type-extension bit followed by the C and B bits. When the remap enable input is low, both tables are skipped and a fixed decode of the page-table bits is used instead. The non-secure attribute is never remapped.

Two 32-bit tables hold the mapping, and each is banked per security world. A coprocessor-style register port reads and writes them. The port applies privilege rules: a privileged access reaches the bank of the world it is issued in, and an unprivileged access gets an undefined-instruction response. The translation path always reads the bank that belongs to the current world.

Top module: `attr_remap_top`

## Requirements
- R1: The register port answers only requests with op1 = 0, major number 10, minor number 2 and op2 of 0 (type table) or 1 (cacheability table). Any other request gets no response: `rsp_valid` stays low in the following cycle and no table changes.
- R2: A privileged access with `world_ns` = 0 reads or writes the secure copy of the selected table. A read returns its contents and a write replaces all 32 bits. The response has `rsp_undef` = 0.
- R3: A privileged access with `world_ns` = 1 reads or writes the non-secure copy. This copy is fully independent of the secure copy.
- R4: An unprivileged access that matches R1 gives `rsp_valid` = 1 and `rsp_undef` = 1 with `rsp_rdata` = 0, and it leaves both tables unchanged.
- R5: The response to a request appears exactly one clock cycle after the request. A write response carries `rsp_rdata` = 0.
- R6: After reset, both copies of the type table hold 0x006382A4 and both copies of the cacheability table hold 0x40E040E0.
- R7: With `remap_en` = 1, the index i = {tex[0], c, b}. `mem_type` comes from type-table bits [2i+1:2i], encoded 00 Strongly Ordered, 01 Device, 10 Normal. Code 11 is reported as 00. `shareable` comes from type-table bit 16+i. tex[2:1] and `s_bit` are ignored.
- R8: When the resolved type is Normal (10), `inner` = cacheability-table bits [2i+1:2i] and `outer` = bits [2i+17:2i+16]. For any other type, both are forced to 00. Cache codes are 00 non-cacheable, 01 write-back with allocate, 10 write-through, 11 write-back without allocate.
- R9: The translation reads the table copy of the world selected by `world_ns`.
- R10: With `remap_en` = 0, the outputs follow a fixed decode:
  - tex = 1xx gives Normal with inner = {c,b}, outer = tex[1:0] and shareable = s_bit.
  - tex = 000: cb 00 gives Strongly Ordered; cb 01 gives shared Device; cb 10 gives Normal 10/10; cb 11 gives Normal 11/11.
  - tex = 001: cb 00 gives Normal 00/00; cb 11 gives Normal 01/01.
  - tex = 010 with cb 00 gives unshared Device.
  - Every other code gives Strongly Ordered.
  - Normal takes shareable from `s_bit`. Strongly Ordered is shareable. Non-Normal types have cacheability 00.
- R11: `ns_out` always equals `ns_in`, whether remapping is on or off.
- R12: With the reset table values, tex[2:1] = 00 and `s_bit` = 0, the outputs with `remap_en` = 1 equal the outputs with `remap_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_req | input | 1 | Register port request strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_op1 | input | 3 | Primary opcode field |
| reg_crn | input | 4 | Major register number |
| reg_crm | input | 4 | Minor register number |
| reg_op2 | input | 3 | Secondary opcode, selects the table |
| reg_wdata | input | 32 | Write data |
| reg_priv | input | 1 | 1 = privileged mode |
| world_ns | input | 1 | Current world, 1 = non-secure |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_undef | output | 1 | Undefined-instruction indication |
| rsp_rdata | output | 32 | Read data |
| remap_en | input | 1 | Enables the two-stage remap |
| tex | input | 3 | Page-table type-extension bits |
| c_bit | input | 1 | Page-table C bit |
| b_bit | input | 1 | Page-table B bit |
| s_bit | input | 1 | Page-table shareable bit |
| ns_in | input | 1 | Page-table non-secure bit |
| mem_type | output | 2 | Resolved memory type |
| shareable | output | 1 | Resolved shareable flag |
| inner | output | 2 | Inner cacheability |
| outer | output | 2 | Outer cacheability |
| ns_out | output | 1 | Non-secure attribute, unaltered |

## Verification
A corrupted table bit shows up on the attribute outputs in the same cycle that an index selecting that entry is presented with remapping enabled. It also shows up on `rsp_rdata` one cycle after a read of that table. A wrong bank select shows as one world's write leaking into the other world's translation or readback. A broken privilege or decode path shows in the cycle after the request, as a missing, extra or wrongly flagged response. Legacy decode faults appear immediately with remapping off, so the fixed-decode codes and the reset-equivalence cases are each compared directly.

// File: rtl/attr_remap_pkg.sv
// Shared constants and types for the attribute remapper.
// Assumes a 3-bit lookup index (eight table entries) and 2-bit codes.
package attr_remap_pkg;
    localparam int REG_W     = 32;
    localparam int IDX_W     = 3;
    localparam int ENTRIES   = 1 << IDX_W;
    localparam int CODE_W    = 2;
    localparam int SHARE_LSB = 16;
    localparam int OUTER_LSB = 16;

    typedef enum logic [CODE_W-1:0] {
        MT_SO     = 2'b00,
        MT_DEV    = 2'b01,
        MT_NORMAL = 2'b10,
        MT_RSVD   = 2'b11
    } mem_type_e;

    localparam logic [CODE_W-1:0] CA_NC   = 2'b00;
    localparam logic [CODE_W-1:0] CA_WBWA = 2'b01;
    localparam logic [CODE_W-1:0] CA_WT   = 2'b10;
    localparam logic [CODE_W-1:0] CA_WB   = 2'b11;

    localparam logic [REG_W-1:0] TYPE_TBL_RST  = 32'h0063_82A4;
    localparam logic [REG_W-1:0] CACHE_TBL_RST = 32'h40E0_40E0;

    typedef struct packed {
        mem_type_e         mtype;
        logic              share;
        logic [CODE_W-1:0] inner;
        logic [CODE_W-1:0] outer;
    } attr_t;
endpackage

// File: rtl/attr_remap_regs.sv
// Banked table storage with a coprocessor-style access port.
// Decodes the fixed register numbers, checks privilege and picks the bank
// from the world of the request. Responds one cycle after each request.
// Assumes at most one request per cycle.
module attr_remap_regs
    import attr_remap_pkg::*;
#(
    parameter int               DW       = REG_W,
    parameter int               WORLDS   = 2,
    parameter logic [DW-1:0]    TYPE_RST = TYPE_TBL_RST,
    parameter logic [DW-1:0]    CACH_RST = CACHE_TBL_RST
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic                     wr,
    input  logic [2:0]               op1,
    input  logic [3:0]               crn,
    input  logic [3:0]               crm,
    input  logic [2:0]               op2,
    input  logic [DW-1:0]            wdata,
    input  logic                     priv,
    input  logic                     world,
    output logic                     rsp_valid,
    output logic                     rsp_undef,
    output logic [DW-1:0]            rsp_rdata,
    output logic [WORLDS-1:0][DW-1:0] type_bank,
    output logic [WORLDS-1:0][DW-1:0] cach_bank
);
    localparam logic [2:0] OP1_ID   = 3'd0;
    localparam logic [3:0] MAJOR_ID = 4'd10;
    localparam logic [3:0] MINOR_ID = 4'd2;
    localparam logic [2:0] SEL_TYPE = 3'd0;
    localparam logic [2:0] SEL_CACH = 3'd1;

    logic          addr_hit;
    logic          pick_type;
    logic          granted;
    logic          do_write;
    logic [DW-1:0] read_word;

    // Decode whether the request targets one of the two tables.
    always_comb begin
        pick_type = (op2 == SEL_TYPE);
        addr_hit  = req && (op1 == OP1_ID) && (crn == MAJOR_ID) &&
                    (crm == MINOR_ID) && (pick_type || op2 == SEL_CACH);
        granted   = addr_hit && priv;
        do_write  = granted && wr;
    end

    // Select read data from the bank of the requesting world.
    always_comb begin
        read_word = pick_type ? type_bank[world] : cach_bank[world];
    end

    genvar w;
    generate
        for (w = 0; w < WORLDS; w++) begin : g_bank
            // Hold one world's copy of both tables.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    type_bank[w] <= TYPE_RST;
                    cach_bank[w] <= CACH_RST;
                end else if (do_write && (int'(world) == w)) begin
                    if (pick_type) type_bank[w] <= wdata;
                    else           cach_bank[w] <= wdata;
                end
            end
        end
    endgenerate

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_undef <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= addr_hit;
            rsp_undef <= addr_hit && !priv;
            rsp_rdata <= (granted && !wr) ? read_word : '0;
        end
    end
endmodule

// File: rtl/attr_remap_legacy.sv
// Fixed decode of page-table bits used when remapping is off.
// Pure combinational; assumes the 3-bit extension field plus C, B and S.
module attr_remap_legacy
    import attr_remap_pkg::*;
(
    input  logic [2:0] tex,
    input  logic       c_bit,
    input  logic       b_bit,
    input  logic       s_bit,
    output attr_t      attr
);
    logic [1:0] cb;

    // Map each raw code to its fixed attributes.
    always_comb begin
        cb   = {c_bit, b_bit};
        attr = '{mtype: MT_SO, share: 1'b1, inner: CA_NC, outer: CA_NC};
        if (tex[2]) begin
            attr = '{mtype: MT_NORMAL, share: s_bit, inner: cb, outer: tex[1:0]};
        end else begin
            unique case ({tex[1:0], cb})
                4'b00_01: attr.mtype = MT_DEV;
                4'b00_10: attr = '{mtype: MT_NORMAL, share: s_bit,
                                   inner: CA_WT, outer: CA_WT};
                4'b00_11: attr = '{mtype: MT_NORMAL, share: s_bit,
                                   inner: CA_WB, outer: CA_WB};
                4'b01_00: attr = '{mtype: MT_NORMAL, share: s_bit,
                                   inner: CA_NC, outer: CA_NC};
                4'b01_11: attr = '{mtype: MT_NORMAL, share: s_bit,
                                   inner: CA_WBWA, outer: CA_WBWA};
                4'b10_00: begin
                    attr.mtype = MT_DEV;
                    attr.share = 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/attr_remap_lookup.sv
// Two chained lookups: the type table gives type and shareability, then
// the cacheability table applies only to Normal entries.
// Assumes the tables are stable while a lookup is in use.
module attr_remap_lookup
    import attr_remap_pkg::*;
#(
    parameter int DW   = REG_W,
    parameter int IW   = IDX_W,
    parameter int NENT = 1 << IW
) (
    input  logic [DW-1:0] type_tbl,
    input  logic [DW-1:0] cach_tbl,
    input  logic [IW-1:0] idx,
    output attr_t         attr
);
    logic [CODE_W-1:0] type_slot  [NENT];
    logic              share_slot [NENT];
    logic [CODE_W-1:0] in_slot    [NENT];
    logic [CODE_W-1:0] out_slot   [NENT];
    logic              unused_type_hi;

    assign unused_type_hi = ^type_tbl[DW-1:SHARE_LSB+NENT];

    genvar i;
    generate
        for (i = 0; i < NENT; i++) begin : g_slot
            // Slice entry i out of both tables.
            always_comb begin
                type_slot[i]  = type_tbl[CODE_W*i +: CODE_W];
                share_slot[i] = type_tbl[SHARE_LSB + i];
                in_slot[i]    = cach_tbl[CODE_W*i +: CODE_W];
                out_slot[i]   = cach_tbl[OUTER_LSB + CODE_W*i +: CODE_W];
            end
        end
    endgenerate

    // Chain stage one into stage two.
    always_comb begin
        attr.share = share_slot[idx];
        attr.inner = CA_NC;
        attr.outer = CA_NC;
        case (type_slot[idx])
            MT_NORMAL: begin
                attr.mtype = MT_NORMAL;
                attr.inner = in_slot[idx];
                attr.outer = out_slot[idx];
            end
            MT_DEV:  attr.mtype = MT_DEV;
            default: attr.mtype = MT_SO;
        endcase
    end
endmodule

// File: rtl/attr_remap_top.sv
// Top of the attribute remapper: banked tables, two-stage lookup and
// a fixed-decode bypass. The non-secure bit passes straight through.
// Assumes world_ns reflects the current world for both ports.
module attr_remap_top
    import attr_remap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_req,
    input  logic        reg_wr,
    input  logic [2:0]  reg_op1,
    input  logic [3:0]  reg_crn,
    input  logic [3:0]  reg_crm,
    input  logic [2:0]  reg_op2,
    input  logic [31:0] reg_wdata,
    input  logic        reg_priv,
    input  logic        world_ns,
    output logic        rsp_valid,
    output logic        rsp_undef,
    output logic [31:0] rsp_rdata,
    input  logic        remap_en,
    input  logic [2:0]  tex,
    input  logic        c_bit,
    input  logic        b_bit,
    input  logic        s_bit,
    input  logic        ns_in,
    output logic [1:0]  mem_type,
    output logic        shareable,
    output logic [1:0]  inner,
    output logic [1:0]  outer,
    output logic        ns_out
);
    localparam int NWORLD = 2;

    logic [NWORLD-1:0][REG_W-1:0] type_bank;
    logic [NWORLD-1:0][REG_W-1:0] cach_bank;
    logic [IDX_W-1:0]             idx;
    attr_t                        remap_attr;
    attr_t                        raw_attr;
    attr_t                        final_attr;

    attr_remap_regs #(.DW(REG_W), .WORLDS(NWORLD)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (reg_req),
        .wr        (reg_wr),
        .op1       (reg_op1),
        .crn       (reg_crn),
        .crm       (reg_crm),
        .op2       (reg_op2),
        .wdata     (reg_wdata),
        .priv      (reg_priv),
        .world     (world_ns),
        .rsp_valid (rsp_valid),
        .rsp_undef (rsp_undef),
        .rsp_rdata (rsp_rdata),
        .type_bank (type_bank),
        .cach_bank (cach_bank)
    );

    assign idx = {tex[0], c_bit, b_bit};

    attr_remap_lookup #(.DW(REG_W), .IW(IDX_W)) u_lookup (
        .type_tbl (type_bank[world_ns]),
        .cach_tbl (cach_bank[world_ns]),
        .idx      (idx),
        .attr     (remap_attr)
    );

    attr_remap_legacy u_legacy (
        .tex   (tex),
        .c_bit (c_bit),
        .b_bit (b_bit),
        .s_bit (s_bit),
        .attr  (raw_attr)
    );

    // Choose remapped or fixed-decode attributes.
    always_comb begin
        final_attr = remap_en ? remap_attr : raw_attr;
    end

    assign mem_type  = final_attr.mtype;
    assign shareable = final_attr.share;
    assign inner     = final_attr.inner;
    assign outer     = final_attr.outer;
    assign ns_out    = ns_in;
endmodule

// File: rtl/attr_remap_chk.sv
// Port-level checker for attr_remap_top, bound to every instance.
module attr_remap_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_req,
    input logic [2:0]  reg_op1,
    input logic [3:0]  reg_crn,
    input logic [3:0]  reg_crm,
    input logic [2:0]  reg_op2,
    input logic        reg_priv,
    input logic        rsp_valid,
    input logic        rsp_undef,
    input logic [31:0] rsp_rdata,
    input logic [1:0]  mem_type,
    input logic [1:0]  inner,
    input logic [1:0]  outer,
    input logic        ns_in,
    input logic        ns_out
);
    logic ours;
    assign ours = (reg_op1 == 3'd0) && (reg_crn == 4'd10) &&
                  (reg_crm == 4'd2) && (reg_op2 <= 3'd1);

    assert_foreign_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && !ours |=> !rsp_valid);
    assert_priv_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && ours && reg_priv |=> rsp_valid && !rsp_undef);
    assert_user_undef_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && ours && !reg_priv |=> rsp_valid && rsp_undef);
    assert_undef_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_undef |-> rsp_valid && rsp_rdata == 32'h0);
    assert_rsp_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(reg_req));
    assert_type_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_type != 2'b11);
    assert_nonnormal_nc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_type != 2'b10 |-> inner == 2'b00 && outer == 2'b00);
    assert_ns_through_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ns_out == ns_in);
endmodule

bind attr_remap_top attr_remap_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_req   (reg_req),
    .reg_op1   (reg_op1),
    .reg_crn   (reg_crn),
    .reg_crm   (reg_crm),
    .reg_op2   (reg_op2),
    .reg_priv  (reg_priv),
    .rsp_valid (rsp_valid),
    .rsp_undef (rsp_undef),
    .rsp_rdata (rsp_rdata),
    .mem_type  (mem_type),
    .inner     (inner),
    .outer     (outer),
    .ns_in     (ns_in),
    .ns_out    (ns_out)
);

// File: tb/attr_remap_top_tb.sv
module attr_remap_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0, reg_wr = 1'b0, reg_priv = 1'b0, world_ns = 1'b0;
    logic [2:0]  reg_op1 = '0, reg_op2 = '0;
    logic [3:0]  reg_crn = '0, reg_crm = '0;
    logic [31:0] reg_wdata = '0;
    logic        rsp_valid, rsp_undef;
    logic [31:0] rsp_rdata;
    logic        remap_en = 1'b0, c_bit = 1'b0, b_bit = 1'b0, s_bit = 1'b0, ns_in = 1'b0;
    logic [2:0]  tex = '0;
    logic [1:0]  mem_type, inner, outer;
    logic        shareable, ns_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    attr_remap_top u_dut (.*);

    // {en, tex[2:0], c, b, s, ns, type[1:0], share, inner[1:0], outer[1:0]}
    localparam int NV = 17;
    localparam logic [14:0] VEC [NV] = '{
        {1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 2'b00, 2'b00},
        {1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 1'b1, 2'b00, 2'b00},
        {1'b0, 3'b000, 1'b1, 1'b0, 1'b1, 1'b0, 2'b10, 1'b1, 2'b10, 2'b10},
        {1'b0, 3'b000, 1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 1'b0, 2'b11, 2'b11},
        {1'b0, 3'b001, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 1'b1, 2'b00, 2'b00},
        {1'b0, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 2'b01, 2'b01},
        {1'b0, 3'b001, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 1'b1, 2'b00, 2'b00},
        {1'b0, 3'b010, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 1'b0, 2'b00, 2'b00},
        {1'b0, 3'b110, 1'b0, 1'b1, 1'b1, 1'b1, 2'b10, 1'b1, 2'b01, 2'b10},
        {1'b0, 3'b011, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 2'b00, 2'b00},
        {1'b1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 2'b00, 2'b00},
        {1'b1, 3'b000, 1'b1, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 2'b11, 2'b11},
        {1'b1, 3'b001, 1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 1'b0, 2'b01, 2'b01},
        {1'b1, 3'b110, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 2'b00, 2'b00},
        {1'b1, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 2'b00, 2'b00},
        {1'b1, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 2'b00, 2'b00},
        {1'b1, 3'b001, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 2'b00, 2'b00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic reg_op(input logic wr, input logic [3:0] crm, input logic [2:0] op2,
                          input logic ns, input logic priv, input logic [31:0] wd,
                          output logic v, output logic u, output logic [31:0] rd);
        @(negedge clk);
        reg_req = 1'b1; reg_wr = wr; reg_op1 = 3'd0; reg_crn = 4'd10;
        reg_crm = crm; reg_op2 = op2; world_ns = ns; reg_priv = priv; reg_wdata = wd;
        @(negedge clk);
        reg_req = 1'b0; reg_wr = 1'b0;
        v = rsp_valid; u = rsp_undef; rd = rsp_rdata;
    endtask

    task automatic xlate(input logic en, input logic [2:0] t, input logic c, input logic b,
                         input logic s, input logic ns, input logic wns);
        @(negedge clk);
        remap_en = en; tex = t; c_bit = c; b_bit = b; s_bit = s; ns_in = ns; world_ns = wns;
        #1;
    endtask

    function automatic logic [31:0] attrs();
        return {25'd0, mem_type, shareable, inner, outer};
    endfunction

    initial begin
        logic v, u;
        logic [31:0] rd;
        logic [6:0] a_off, a_on;

        repeat (3) @(negedge clk);
        chk("R5 no response in reset", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;

        // R6 reset contents of every copy
        reg_op(1'b0, 4'd2, 3'd0, 1'b0, 1'b1, 0, v, u, rd);
        chk("R6 sec type reset", rd, 32'h0063_82A4);
        chk("R2 read not undef", {30'd0, v, u}, 32'd2);
        reg_op(1'b0, 4'd2, 3'd1, 1'b0, 1'b1, 0, v, u, rd);
        chk("R6 sec cache reset", rd, 32'h40E0_40E0);
        reg_op(1'b0, 4'd2, 3'd0, 1'b1, 1'b1, 0, v, u, rd);
        chk("R6 ns type reset", rd, 32'h0063_82A4);
        reg_op(1'b0, 4'd2, 3'd1, 1'b1, 1'b1, 0, v, u, rd);
        chk("R6 ns cache reset", rd, 32'h40E0_40E0);

        // R7 R8 R10 R11 table walk with reset contents
        for (int k = 0; k < NV; k++) begin
            xlate(VEC[k][14], VEC[k][13:11], VEC[k][10], VEC[k][9], VEC[k][8], VEC[k][7], 1'b0);
            chk(VEC[k][14] ? "R7 R8 remap vector" : "R10 fixed decode vector",
                attrs(), {25'd0, VEC[k][6:0]});
            chk("R11 ns passthrough", {31'd0, ns_out}, {31'd0, VEC[k][7]});
        end

        // R12 reset equivalence over all eight indices
        for (int i = 0; i < 8; i++) begin
            xlate(1'b0, {2'b00, i[2]}, i[1], i[0], 1'b0, 1'b0, 1'b0);
            a_off = attrs()[6:0];
            xlate(1'b1, {2'b00, i[2]}, i[1], i[0], 1'b0, 1'b0, 1'b0);
            a_on = attrs()[6:0];
            chk("R12 reset tables match fixed decode", {25'd0, a_on}, {25'd0, a_off});
        end

        // R2 secure writes
        reg_op(1'b1, 4'd2, 3'd0, 1'b0, 1'b1, 32'h0001_0002, v, u, rd);
        chk("R5 write response data zero", {30'd0, v, u} | rd, 32'd2);
        reg_op(1'b1, 4'd2, 3'd1, 1'b0, 1'b1, 32'h0002_0001, v, u, rd);
        reg_op(1'b0, 4'd2, 3'd0, 1'b0, 1'b1, 0, v, u, rd);
        chk("R2 sec type readback", rd, 32'h0001_0002);
        reg_op(1'b0, 4'd2, 3'd1, 1'b0, 1'b1, 0, v, u, rd);
        chk("R2 sec cache readback", rd, 32'h0002_0001);
        reg_op(1'b0, 4'd2, 3'd0, 1'b1, 1'b1, 0, v, u, rd);
        chk("R3 ns copy untouched", rd, 32'h0063_82A4);

        // R9 translation follows world: idx0 Normal sh1 in01 out10 (secure)
        xlate(1'b1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 R8 secure world lookup", attrs(), {25'd0, 2'b10, 1'b1, 2'b01, 2'b10});
        xlate(1'b1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R9 ns world lookup", attrs(), {25'd0, 2'b00, 1'b1, 2'b00, 2'b00});

        // R3 non-secure writes; R8 forcing for Device
        reg_op(1'b1, 4'd2, 3'd0, 1'b1, 1'b1, 32'h0000_0004, v, u, rd);
        reg_op(1'b1, 4'd2, 3'd1, 1'b1, 1'b1, 32'hFFFF_FFFF, v, u, rd);
        reg_op(1'b0, 4'd2, 3'd0, 1'b1, 1'b1, 0, v, u, rd);
        chk("R3 ns type readback", rd, 32'h0000_0004);
        reg_op(1'b0, 4'd2, 3'd0, 1'b0, 1'b1, 0, v, u, rd);
        chk("R3 secure copy kept", rd, 32'h0001_0002);
        xlate(1'b1, 3'b000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        chk("R8 device forces non-cacheable", attrs(), {25'd0, 2'b01, 1'b0, 2'b00, 2'b00});
        xlate(1'b0, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R10 bypass ignores written tables", attrs(), {25'd0, 2'b10, 1'b0, 2'b11, 2'b11});

        // R4 user access
        reg_op(1'b1, 4'd2, 3'd0, 1'b0, 1'b0, 32'h0, v, u, rd);
        chk("R4 user write undef", {30'd0, v, u}, 32'd3);
        chk("R4 user data zero", rd, 32'd0);
        reg_op(1'b0, 4'd2, 3'd1, 1'b0, 1'b0, 0, v, u, rd);
        chk("R4 user read undef zero", {30'd0, v, u} | rd, 32'd3);
        reg_op(1'b0, 4'd2, 3'd0, 1'b0, 1'b1, 0, v, u, rd);
        chk("R4 user write had no effect", rd, 32'h0001_0002);

        // R1 foreign register numbers
        reg_op(1'b1, 4'd2, 3'd2, 1'b0, 1'b1, 32'h0, v, u, rd);
        chk("R1 op2=2 no response", {31'd0, v}, 32'd0);
        reg_op(1'b1, 4'd3, 3'd0, 1'b0, 1'b1, 32'h0, v, u, rd);
        chk("R1 minor=3 no response", {31'd0, v}, 32'd0);
        reg_op(1'b0, 4'd2, 3'd0, 1'b0, 1'b1, 0, v, u, rd);
        chk("R1 foreign writes ignored", rd, 32'h0001_0002);

        // R7 reserved type code 11 reads as Strongly Ordered
        reg_op(1'b1, 4'd2, 3'd0, 1'b0, 1'b1, 32'h0000_0003, v, u, rd);
        xlate(1'b1, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R7 code 11 as strongly ordered", attrs(), {25'd0, 2'b00, 1'b0, 2'b00, 2'b00});

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule